// File: doc/BRIEF.md
# Memory Pattern Sequencer

This block plays one access to an external memory as a short microprogram. A 64-entry table of 32-bit control words is loaded while the block is idle. A start request then names the table index where the program begins. On each clock the sequencer drives the strobe field of the current word onto its registered strobe outputs and moves to the next entry. It stops at the word that carries the end flag.

Any word may also carry a stall flag. When the sequencer reaches such a word it stops there and keeps the strobes frozen for as long as the slow device holds its wait line. Once the wait line drops, the sequencer continues with the entry after the stalled one, so a stalled word is never replayed. The wait line is asynchronous to the sequencer and passes through a two-stage synchronizer first. A table strobe used to latch read data therefore cannot fire while the device is still asking for time. One cycle after the end word has been driven, the strobes return to their idle level and a one-cycle completion pulse is raised.

Top module: `mem_pattern_seq`

## Requirements
- R1: After reset, `strobe_o` is all zeros and `done_o` is low.
- R2: A start request sampled while idle begins the program at `start_idx_i`. The strobe field of entry start+k is on `strobe_o` from the (k+1)th rising edge after the edge that sampled `start_i`.
- R3: Table words are laid out as follows: bit 31 is the end flag, bit 30 is the stall flag and bits [7:0] are the strobe levels. The other bits are ignored.
- R4: Words without a stall flag advance the program by one entry per cycle, and the index wraps from 63 to 0.
- R5: A word with the stall flag is held on `strobe_o`, unchanged, for as long as the synchronized wait line is high.
- R6: The first edge that samples `mem_wait_i` low during a stall is followed by two more cycles of the stalled word. The following entry then appears on the third edge after that sampling edge. If the wait line is already low, a stall word stays for exactly two cycles.
- R7: After the end word is driven, the next edge returns `strobe_o` to zero and raises `done_o` for exactly one cycle.
- R8: A start request that arrives while a program is running has no effect on the running sequence and produces no second completion.
- R9: Table writes are accepted only while idle. A write issued while a program runs leaves the entry unchanged.
- R10: A word that carries both the stall flag and the end flag stalls first. It then ends the program at the release point given in R6, without reading a further entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run a program |
| start_idx_i | input | 6 | Table index of the first word |
| tbl_we_i | input | 1 | Table write enable (honoured only when idle) |
| tbl_addr_i | input | 6 | Table write index |
| tbl_wdata_i | input | 32 | Table write word |
| mem_wait_i | input | 1 | Asynchronous wait line from the slow device |
| strobe_o | output | 8 | Registered memory strobe levels |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong index or a wrong state shows up on `strobe_o` on the very next edge, as a word from the wrong entry or as a frozen or early-moving level. This is why the bench compares every strobe value cycle by cycle against the table it loaded. A synchronizer of the wrong depth shifts the release point of a stall by whole cycles, and an exact count of the stalled cycles exposes that. A fault in the end or completion logic appears as a missing, doubled or late `done_o` pulse, or as strobes that never return to zero.

// File: rtl/mps_pkg.sv
package mps_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mps_table.sv
module mps_table #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mps_sync.sv
module mps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mps_ctrl.sv
module mps_ctrl
    import mps_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int WORD_W   = 32,
    parameter int STROBE_W = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int END_B   = WORD_W - 1,
    localparam int STALL_B = WORD_W - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       start_idx_i,
    input  logic [WORD_W-1:0]   word_i,
    input  logic                wait_s_i,
    output logic [AW-1:0]       ptr_o,
    output logic                idle_o,
    output logic [STROBE_W-1:0] strobe_o,
    output logic                done_o
);
    typedef struct packed {
        seq_state_e          state;
        logic [AW-1:0]       ptr;
        logic [STROBE_W-1:0] strb;
        logic                fin;
        logic                done;
    } ctrl_t;

    ctrl_t q, d;

    logic w_end, w_stall;
    assign w_end   = word_i[END_B];
    assign w_stall = word_i[STALL_B];

    always_comb begin
        d      = q;
        d.fin  = 1'b0;
        d.done = q.fin;
        unique case (q.state)
            SEQ_IDLE: begin
                d.strb = '0;
                if (start_i) begin
                    d.ptr   = start_idx_i;
                    d.state = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                d.strb = word_i[STROBE_W-1:0];
                if (w_stall) begin
                    d.state = SEQ_HOLD;
                end else if (w_end) begin
                    d.state = SEQ_IDLE;
                    d.fin   = 1'b1;
                end else begin
                    d.ptr = q.ptr + 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (!wait_s_i) begin
                    if (w_end) begin
                        d.state = SEQ_IDLE;
                        d.fin   = 1'b1;
                    end else begin
                        d.state = SEQ_RUN;
                        d.ptr   = q.ptr + 1'b1;
                    end
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, ptr: '0, strb: '0, fin: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ptr_o    = q.ptr;
    assign idle_o   = (q.state == SEQ_IDLE);
    assign strobe_o = q.strb;
    assign done_o   = q.done;

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R5: a stall persists while the synchronized wait line is high
    assert_hold_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_HOLD && wait_s_i) |=>
            (q.state == SEQ_HOLD && $stable(q.ptr) && $stable(q.strb)));

    // R4: plain words advance by exactly one entry, start requests ignored
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_RUN && !w_stall && !w_end) |=>
            (q.state == SEQ_RUN && q.ptr == AW'($past(q.ptr) + 1'b1)));

    // R7: an end word without stall finishes the program
    assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_RUN && !w_stall && w_end) |=>
            (q.state == SEQ_IDLE) ##1 q.done);
endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq #(
    parameter int DEPTH       = 64,
    parameter int WORD_W      = 32,
    parameter int STROBE_W    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       start_idx_i,
    input  logic                tbl_we_i,
    input  logic [AW-1:0]       tbl_addr_i,
    input  logic [WORD_W-1:0]   tbl_wdata_i,
    input  logic                mem_wait_i,
    output logic [STROBE_W-1:0] strobe_o,
    output logic                done_o
);
    logic [AW-1:0]     ptr;
    logic [WORD_W-1:0] word;
    logic              idle;
    logic              wait_s;
    logic              we_ok;

    assign we_ok = tbl_we_i & idle;

    mps_table #(.DEPTH(DEPTH), .WORD_W(WORD_W)) table_i (
        .clk     (clk),
        .we_i    (we_ok),
        .waddr_i (tbl_addr_i),
        .wdata_i (tbl_wdata_i),
        .raddr_i (ptr),
        .rdata_o (word)
    );

    mps_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mem_wait_i),
        .sync_o  (wait_s)
    );

    mps_ctrl #(.DEPTH(DEPTH), .WORD_W(WORD_W), .STROBE_W(STROBE_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_idx_i (start_idx_i),
        .word_i      (word),
        .wait_s_i    (wait_s),
        .ptr_o       (ptr),
        .idle_o      (idle),
        .strobe_o    (strobe_o),
        .done_o      (done_o)
    );

    // R8: a running program keeps its pointer path despite new start requests
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && start_i && !done_o) |=> (idle || ptr != start_idx_i || $past(ptr) == start_idx_i
            || ptr == AW'($past(ptr) + 1'b1) || ptr == $past(ptr)));
endmodule

// File: tb/mem_pattern_seq_tb_top.sv
module mem_pattern_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  start_idx_i = '0;
    logic        tbl_we_i = 1'b0;
    logic [5:0]  tbl_addr_i = '0;
    logic [31:0] tbl_wdata_i = '0;
    logic        mem_wait_i = 1'b0;
    logic [7:0]  strobe_o;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mem_pattern_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_idx_i(start_idx_i),
        .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_wdata_i(tbl_wdata_i),
        .mem_wait_i(mem_wait_i), .strobe_o(strobe_o), .done_o(done_o)
    );

    // {start index, length}
    localparam logic [11:0] VECS [6] = '{
        {6'd0, 6'd1}, {6'd5, 6'd3}, {6'd20, 6'd8},
        {6'd62, 6'd4}, {6'd63, 6'd1}, {6'd40, 6'd16}
    };

    localparam logic [31:0] END_F   = 32'h8000_0000;
    localparam logic [31:0] STALL_F = 32'h4000_0000;

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 29 + seed * 7 + 3) & 255);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] w);
        tbl_we_i = 1'b1; tbl_addr_i = 6'(a); tbl_wdata_i = w;
        tick();
        tbl_we_i = 1'b0;
    endtask

    task automatic go(input int idx);
        start_i = 1'b1; start_idx_i = 6'(idx);
        tick();
        start_i = 1'b0;
    endtask

    task automatic expect_strb(input logic [7:0] e, input logic dn, input string req);
        tick();
        chk(strobe_o == e, req, strobe_o, e);
        chk(done_o == dn, req, done_o, dn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(strobe_o == 8'h00, "R1", strobe_o, 0);
        chk(done_o == 1'b0, "R1", done_o, 0);
        rst_n = 1'b1;
        tick();
        chk(strobe_o == 8'h00 && done_o == 1'b0, "R1", strobe_o, 0);

        // Vector walk: R2, R3, R4 (wrap at 62 and 63), R7
        for (int v = 0; v < 6; v++) begin
            int idx = int'(VECS[v][11:6]);
            int len = int'(VECS[v][5:0]);
            for (int k = 0; k < len; k++) begin
                wr((idx + k) % 64, {(k == len - 1), 1'b0, 22'h2A_5A5A, pat((idx + k) % 64, v)});
            end
            go(idx);
            for (int k = 0; k < len; k++) begin
                expect_strb(pat((idx + k) % 64, v), 1'b0, "R2_R3_R4");
            end
            expect_strb(8'h00, 1'b1, "R7");
            expect_strb(8'h00, 1'b0, "R7");
        end

        // R8: start while busy is ignored
        for (int k = 0; k < 4; k++) wr(10 + k, (k == 3 ? END_F : 32'h0) | 32'(pat(10 + k, 9)));
        wr(30, END_F | 32'h0000_00EE);
        go(10);
        start_i = 1'b1; start_idx_i = 6'd30;
        tick();
        chk(strobe_o == pat(10, 9), "R8", strobe_o, pat(10, 9));
        tick();
        start_i = 1'b0;
        chk(strobe_o == pat(11, 9), "R8", strobe_o, pat(11, 9));
        expect_strb(pat(12, 9), 1'b0, "R8");
        expect_strb(pat(13, 9), 1'b0, "R8");
        expect_strb(8'h00, 1'b1, "R8");
        expect_strb(8'h00, 1'b0, "R8");
        expect_strb(8'h00, 1'b0, "R8");

        // R9: write while busy is dropped
        go(10);
        tbl_we_i = 1'b1; tbl_addr_i = 6'd12; tbl_wdata_i = END_F | 32'h0000_0077;
        tick();
        tbl_we_i = 1'b0;
        chk(strobe_o == pat(10, 9), "R9", strobe_o, pat(10, 9));
        expect_strb(pat(11, 9), 1'b0, "R9");
        expect_strb(pat(12, 9), 1'b0, "R9");
        expect_strb(pat(13, 9), 1'b0, "R9");
        expect_strb(8'h00, 1'b1, "R9");

        // R6: stall word with wait already low lasts two cycles
        wr(48, 32'h0000_0011);
        wr(49, STALL_F | 32'h0000_0022);
        wr(50, END_F | 32'h0000_0033);
        go(48);
        expect_strb(8'h11, 1'b0, "R6");
        expect_strb(8'h22, 1'b0, "R6");
        expect_strb(8'h22, 1'b0, "R6");
        expect_strb(8'h33, 1'b0, "R6");
        expect_strb(8'h00, 1'b1, "R6");

        // R5, R6: held stall then release timing
        mem_wait_i = 1'b1;
        repeat (3) tick();
        go(48);
        expect_strb(8'h11, 1'b0, "R5");
        expect_strb(8'h22, 1'b0, "R5");
        for (int i = 0; i < 5; i++) expect_strb(8'h22, 1'b0, "R5");
        mem_wait_i = 1'b0;
        for (int i = 0; i < 3; i++) expect_strb(8'h22, 1'b0, "R6");
        expect_strb(8'h33, 1'b0, "R6");
        expect_strb(8'h00, 1'b1, "R6");

        // R10: stall plus end
        wr(56, 32'h0000_0044);
        wr(57, END_F | STALL_F | 32'h0000_0055);
        mem_wait_i = 1'b1;
        repeat (3) tick();
        go(56);
        expect_strb(8'h44, 1'b0, "R10");
        expect_strb(8'h55, 1'b0, "R10");
        for (int i = 0; i < 4; i++) expect_strb(8'h55, 1'b0, "R10");
        mem_wait_i = 1'b0;
        for (int i = 0; i < 3; i++) expect_strb(8'h55, 1'b0, "R10");
        expect_strb(8'h00, 1'b1, "R10");
        expect_strb(8'h00, 1'b0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule